// File: doc/BRIEF.md
# JTAG Configuration Hold and Flash Ownership Arbiter

This block joins a standard four-wire test access port to a shared flash bus. Two private instructions act on a downstream FPGA: one pulls an active-low initiate-configuration line low, which keeps that device in reset; the other lets the line go high again, so that the device starts configuration from whatever the flash now holds. A third private instruction marks in-system programming through the test port as active. That mode asks for the flash in the same way as a bus master.

Three masters compete for the flash: the JTAG programming path, an external processor interface, and the internal configuration engine. The hold and programming flags pass from the TCK domain into the system clock domain through a two-flop synchroniser. In that domain an arbiter gives out one grant at a time. The grant is not pre-emptive. The one exception is the internal engine, which loses its grant as soon as the synchronised hold is seen.

The request and grant pins are plain level signals and carry no data. A master keeps its request high for as long as it needs the bus. Once granted, it keeps the grant until it lowers the request.

Top module: `cfg_hold_arbiter`

## Requirements
- R1: After a TAP reset (trst_n low, or TMS held high for five TCK rising edges), the controller is in Test-Logic-Reset and IDCODE (opcode 10'h006) is the active instruction. A Shift-DR then returns the 32-bit identification value on tdo, least significant bit first.
- R2: The instruction register is 10 bits. Capture-IR loads it with 10'b0000000001, and Shift-IR shifts it out on tdo least significant bit first. The new opcode enters on tdi and takes effect at Update-IR.
- R3: Any opcode other than 10'h006, 10'h0E5, 10'h0E6 and 10'h0E7 selects a one-bit bypass register. That register captures 0, so tdo repeats tdi one TCK cycle later.
- R4: Update-IR of the hold opcode 10'h0E5 drives init_conf_n low on that TCK rising edge.
- R5: Update-IR of the release opcode 10'h0E6 drives init_conf_n high on that TCK rising edge. Any other opcode leaves the hold level as it was.
- R6: A TCK rising edge while the controller is in Test-Logic-Reset clears the hold, so init_conf_n is high. The same edge also ends JTAG programming.
- R7: The hold reaches the arbiter through two clk flops. The internal engine's grant drops by the third clk rising edge after init_conf_n falls, and it is not given again while the hold is set.
- R8: When no grant is held, the arbiter chooses by priority: JTAG programming first, then req_ext, then req_int. The internal engine can win only while no hold is seen.
- R9: A grant given to the external or JTAG master stays until that master's request drops. A grant given to the internal engine stays until its request drops or the hold arrives.
- R10: At most one grant is high in any cycle. gnt_ext is never high while gnt_jtag is high.
- R11: The program-flash opcode 10'h0E7 is a JTAG flash request for as long as it is the active instruction, after synchronisation. It is granted whether or not a hold was issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, up to 10 MHz |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on TCK rise |
| tdi | input | 1 | Test data in, sampled on TCK rise |
| tdo | output | 1 | Test data out, updated on TCK fall |
| clk | input | 1 | System clock of the arbiter |
| rst_n | input | 1 | Asynchronous system reset, active low |
| req_ext | input | 1 | Flash request from the external processor interface |
| req_int | input | 1 | Flash request from the internal configuration engine |
| gnt_jtag | output | 1 | Flash granted to JTAG programming |
| gnt_ext | output | 1 | Flash granted to the external interface |
| gnt_int | output | 1 | Flash granted to the internal engine |
| init_conf_n | output | 1 | Active-low initiate-configuration / hold line |

## Verification
Two events can meet on the same clk edge. The first is the synchronised hold taking the flash away from the internal engine. The second is the same edge granting the flash to a new winner, which can be an external request that has just risen or a JTAG programming flag that arrives through the synchroniser. The bench sets this up by loading hold and programming instructions while req_int owns the bus, and by raising req_ext a few clk cycles after an Update-IR. A behavioural model uses the bench's own record of when each Update-IR edge happened. It delays that record by two clk samples, re-runs the priority-and-hold rules on every clk edge, and compares all three grants against the design on every cycle.

// File: rtl/cfg_hold_pkg.sv
package cfg_hold_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'h0,
    ST_RTI    = 4'h1,
    ST_SELDR  = 4'h2,
    ST_CAPDR  = 4'h3,
    ST_SHDR   = 4'h4,
    ST_EX1DR  = 4'h5,
    ST_PAUDR  = 4'h6,
    ST_EX2DR  = 4'h7,
    ST_UPDDR  = 4'h8,
    ST_SELIR  = 4'h9,
    ST_CAPIR  = 4'hA,
    ST_SHIR   = 4'hB,
    ST_EX1IR  = 4'hC,
    ST_PAUIR  = 4'hD,
    ST_EX2IR  = 4'hE,
    ST_UPDIR  = 4'hF
  } tap_state_t;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_JTAG = 2'd1,
    OWN_EXT  = 2'd2,
    OWN_INT  = 2'd3
  } owner_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import cfg_hold_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_TLR:   nxt = tms ? ST_TLR   : ST_RTI;
      ST_RTI:   nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELDR: nxt = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: nxt = tms ? ST_UPDDR : ST_PAUDR;
      ST_PAUDR: nxt = tms ? ST_EX2DR : ST_PAUDR;
      ST_EX2DR: nxt = tms ? ST_UPDDR : ST_SHDR;
      ST_UPDDR: nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELIR: nxt = tms ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: nxt = tms ? ST_UPDIR : ST_PAUIR;
      ST_PAUIR: nxt = tms ? ST_EX2IR : ST_PAUIR;
      ST_EX2IR: nxt = tms ? ST_UPDIR : ST_SHIR;
      ST_UPDIR: nxt = tms ? ST_SELDR : ST_RTI;
      default:  nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import cfg_hold_pkg::*;
#(
  parameter int              IR_W       = 10,
  parameter logic [IR_W-1:0] OPC_IDCODE = 'h006,
  parameter logic [IR_W-1:0] OPC_HOLD   = 'h0E5,
  parameter logic [IR_W-1:0] OPC_REL    = 'h0E6,
  parameter logic [IR_W-1:0] OPC_PROG   = 'h0E7
)(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_t state,
  output logic       ir_out,
  output logic       sel_idcode,
  output logic       hold_q,
  output logic       isp_q
);

  localparam logic [IR_W-1:0] CAPT = IR_W'(1);

  logic [IR_W-1:0] sh_q;
  logic [IR_W-1:0] act_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sh_q   <= CAPT;
      act_q  <= OPC_IDCODE;
      hold_q <= 1'b0;
    end else begin
      unique case (state)
        ST_TLR: begin
          act_q  <= OPC_IDCODE;
          hold_q <= 1'b0;
        end
        ST_CAPIR: sh_q <= CAPT;
        ST_SHIR:  sh_q <= {tdi, sh_q[IR_W-1:1]};
        ST_UPDIR: begin
          act_q <= sh_q;
          if (sh_q == OPC_HOLD)     hold_q <= 1'b1;
          else if (sh_q == OPC_REL) hold_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign ir_out     = sh_q[0];
  assign sel_idcode = (act_q == OPC_IDCODE);
  assign isp_q      = (act_q == OPC_PROG);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import cfg_hold_pkg::*;
#(
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h1234_50DD
)(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_t state,
  input  logic       sel_idcode,
  input  logic       ir_out,
  output logic       tdo
);

  logic [ID_W-1:0] id_q;
  logic            byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_q  <= ID_VAL;
      byp_q <= 1'b0;
    end else if (state == ST_CAPDR) begin
      id_q  <= ID_VAL;
      byp_q <= 1'b0;
    end else if (state == ST_SHDR) begin
      if (sel_idcode) id_q  <= {tdi, id_q[ID_W-1:1]};
      else            byp_q <= tdi;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                tdo <= 1'b0;
    else if (state == ST_SHIR)  tdo <= ir_out;
    else if (state == ST_SHDR)  tdo <= sel_idcode ? id_q[0] : byp_q;
    else                        tdo <= 1'b0;
  end

endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[0] <= '0;
        else        st_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= '0;
        else        st_q[g] <= st_q[g-1];
      end
    end
  end

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/flash_arbiter.sv
module flash_arbiter
  import cfg_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_s,
  input  logic isp_s,
  input  logic req_ext,
  input  logic req_int,
  output logic gnt_jtag,
  output logic gnt_ext,
  output logic gnt_int
);

  owner_t own_q, own_d;
  logic   int_ok, keep;

  assign int_ok = req_int && !hold_s;

  always_comb begin
    unique case (own_q)
      OWN_JTAG: keep = isp_s;
      OWN_EXT:  keep = req_ext;
      OWN_INT:  keep = int_ok;
      default:  keep = 1'b0;
    endcase
  end

  always_comb begin
    if (keep)         own_d = own_q;
    else if (isp_s)   own_d = OWN_JTAG;
    else if (req_ext) own_d = OWN_EXT;
    else if (int_ok)  own_d = OWN_INT;
    else              own_d = OWN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end

  assign gnt_jtag = (own_q == OWN_JTAG);
  assign gnt_ext  = (own_q == OWN_EXT);
  assign gnt_int  = (own_q == OWN_INT);

endmodule

// File: rtl/cfg_hold_arbiter.sv
module cfg_hold_arbiter
  import cfg_hold_pkg::*;
#(
  parameter int              IR_W        = 10,
  parameter logic [IR_W-1:0] OPC_IDCODE  = 'h006,
  parameter logic [IR_W-1:0] OPC_HOLD    = 'h0E5,
  parameter logic [IR_W-1:0] OPC_REL     = 'h0E6,
  parameter logic [IR_W-1:0] OPC_PROG    = 'h0E7,
  parameter int              ID_W        = 32,
  parameter logic [ID_W-1:0] ID_VAL      = 32'h1234_50DD,
  parameter int              SYNC_STAGES = 2
)(
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  input  logic clk,
  input  logic rst_n,
  input  logic req_ext,
  input  logic req_int,
  output logic gnt_jtag,
  output logic gnt_ext,
  output logic gnt_int,
  output logic init_conf_n
);

  localparam int FLAG_W = 2;

  tap_state_t        tap_st;
  logic              ir_out, sel_idcode, hold_q, isp_q;
  logic [FLAG_W-1:0] flags_s;
  logic              hold_s, isp_s;

  tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (tap_st)
  );

  tap_ir #(
    .IR_W       (IR_W),
    .OPC_IDCODE (OPC_IDCODE),
    .OPC_HOLD   (OPC_HOLD),
    .OPC_REL    (OPC_REL),
    .OPC_PROG   (OPC_PROG)
  ) u_ir (
    .tck        (tck),
    .trst_n     (trst_n),
    .tdi        (tdi),
    .state      (tap_st),
    .ir_out     (ir_out),
    .sel_idcode (sel_idcode),
    .hold_q     (hold_q),
    .isp_q      (isp_q)
  );

  tap_dr #(
    .ID_W   (ID_W),
    .ID_VAL (ID_VAL)
  ) u_dr (
    .tck        (tck),
    .trst_n     (trst_n),
    .tdi        (tdi),
    .state      (tap_st),
    .sel_idcode (sel_idcode),
    .ir_out     (ir_out),
    .tdo        (tdo)
  );

  bit_sync #(
    .W      (FLAG_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({isp_q, hold_q}),
    .q     (flags_s)
  );

  assign hold_s = flags_s[0];
  assign isp_s  = flags_s[1];

  flash_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_s   (hold_s),
    .isp_s    (isp_s),
    .req_ext  (req_ext),
    .req_int  (req_int),
    .gnt_jtag (gnt_jtag),
    .gnt_ext  (gnt_ext),
    .gnt_int  (gnt_int)
  );

  assign init_conf_n = ~hold_q;

endmodule

// File: rtl/cfg_hold_arbiter_chk.sv
module cfg_hold_arbiter_chk
  import cfg_hold_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tck,
  input logic       trst_n,
  input tap_state_t tap_st,
  input logic       hold_s,
  input logic       req_ext,
  input logic       req_int,
  input logic       gnt_jtag,
  input logic       gnt_ext,
  input logic       gnt_int,
  input logic       init_conf_n
);

  p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_jtag, gnt_ext, gnt_int}));

  p_ext_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_ext && req_ext) |=> gnt_ext);

  p_ext_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_ext && !req_ext) |=> !gnt_ext);

  p_int_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_int && !req_int) |=> !gnt_int);

  p_hold_blocks_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_s |=> !gnt_int);

  p_tlr_release_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_st == ST_TLR) |=> init_conf_n);

  p_hold_on_update_r4: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(init_conf_n) |-> ($past(tap_st) == ST_UPDIR));

  p_release_on_update_r5: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(init_conf_n) |-> ($past(tap_st) == ST_UPDIR || $past(tap_st) == ST_TLR));

endmodule

bind cfg_hold_arbiter cfg_hold_arbiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tck         (tck),
  .trst_n      (trst_n),
  .tap_st      (tap_st),
  .hold_s      (hold_s),
  .req_ext     (req_ext),
  .req_int     (req_int),
  .gnt_jtag    (gnt_jtag),
  .gnt_ext     (gnt_ext),
  .gnt_int     (gnt_int),
  .init_conf_n (init_conf_n)
);

// File: tb/cfg_hold_arbiter_tb.sv
module cfg_hold_arbiter_tb;

  localparam logic [31:0] ID    = 32'h1234_50DD;
  localparam logic [9:0]  HOLD  = 10'h0E5;
  localparam logic [9:0]  REL   = 10'h0E6;
  localparam logic [9:0]  PROG  = 10'h0E7;
  localparam logic [9:0]  BYP   = 10'h3FF;

  logic clk = 0, rst_n = 0, tck = 0, trst_n = 0, tms = 1, tdi = 0;
  logic req_ext = 0, req_int = 0;
  logic tdo, gnt_jtag, gnt_ext, gnt_int, init_conf_n;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side record of TCK-domain flags, set at the Update-IR edge
  bit hold_tck = 0, isp_tck = 0;
  // behavioural reference of the system-domain arbitration
  int m_own = 0;
  bit m_h1 = 0, m_h2 = 0, m_i1 = 0, m_i2 = 0;

  always #10 clk = ~clk;

  cfg_hold_arbiter u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .clk(clk), .rst_n(rst_n), .req_ext(req_ext), .req_int(req_int),
    .gnt_jtag(gnt_jtag), .gnt_ext(gnt_ext), .gnt_int(gnt_int),
    .init_conf_n(init_conf_n)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: two-sample delay of the bench's flags, then priority rules
  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = 0; m_h1 = 0; m_h2 = 0; m_i1 = 0; m_i2 = 0;
    end else begin
      bit keep;
      keep = (m_own == 1 && m_i2) || (m_own == 2 && req_ext) ||
             (m_own == 3 && req_int && !m_h2);
      if (!keep)
        m_own = m_i2 ? 1 : req_ext ? 2 : (req_int && !m_h2) ? 3 : 0;
      m_h2 = m_h1; m_h1 = hold_tck;
      m_i2 = m_i1; m_i1 = isp_tck;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] e, a;
      e = {m_own == 1, m_own == 2, m_own == 3};
      a = {gnt_jtag, gnt_ext, gnt_int};
      check(a == e, "R8 grant vector vs model", 64'(a), 64'(e));
    end
  end

  task automatic cyc(input logic m, input logic d, output logic o);
    tms = m; tdi = d;
    #50; o = tdo; tck = 1;
    #50; tck = 0;
  endtask

  task automatic tap_reset();
    for (int i = 0; i < 5; i++) begin
      tms = 1;
      #50; tck = 1;
      if (i == 3) begin hold_tck = 0; isp_tck = 0; end
      #50; tck = 0;
    end
    begin logic o; cyc(0, 0, o); end
  endtask

  task automatic load_ir(input logic [9:0] opc, output logic [9:0] cap);
    logic o;
    cyc(1, 0, o); cyc(1, 0, o); cyc(0, 0, o); cyc(0, 0, o);
    for (int i = 0; i < 10; i++) begin
      cyc(i == 9, opc[i], o);
      cap[i] = o;
    end
    cyc(1, 0, o);
    tms = 0;
    #50; tck = 1;
    if (opc == HOLD) hold_tck = 1;
    else if (opc == REL) hold_tck = 0;
    isp_tck = (opc == PROG);
    #50; tck = 0;
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    cyc(1, 0, o); cyc(0, 0, o); cyc(0, 0, o);
    for (int i = 0; i < n; i++) begin
      cyc(i == n - 1, din[i], o);
      dout[i] = o;
    end
    cyc(1, 0, o); cyc(0, 0, o);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] dout;
    logic [9:0]  cap;
    #105;
    trst_n = 1; rst_n = 1;
    #20;
    check(init_conf_n == 1, "R6 reset init_conf_n", 64'(init_conf_n), 1);
    check({gnt_jtag, gnt_ext, gnt_int} == 0, "R10 reset grants",
          64'({gnt_jtag, gnt_ext, gnt_int}), 0);
    tap_reset();

    // R1: identification after reset
    shift_dr(32, 64'h0, dout);
    check(dout[31:0] == ID, "R1 idcode", dout, 64'(ID));

    // R2: capture pattern; R3: bypass
    load_ir(BYP, cap);
    check(cap == 10'h001, "R2 ir capture", 64'(cap), 1);
    shift_dr(9, 64'h0A5, dout);
    check(dout[8:0] == {8'hA5, 1'b0}, "R3 bypass delay", dout, 64'({8'hA5, 1'b0}));

    // R8: external beats internal when idle
    req_int = 1; req_ext = 1;
    #60;
    check(gnt_ext && !gnt_int, "R8 ext over int", 64'({gnt_ext, gnt_int}), 2);
    req_ext = 0;
    #60;
    check(gnt_int == 1, "R9 handover to int", 64'(gnt_int), 1);

    // R4 and R7: hold pulls the line low and strips the internal grant
    load_ir(HOLD, cap);
    check(init_conf_n == 0, "R4 hold drives low", 64'(init_conf_n), 0);
    #100;
    check(gnt_int == 0, "R7 int grant removed", 64'(gnt_int), 0);

    // R11 with hold; R10 ext denied
    load_ir(PROG, cap);
    #100;
    check(gnt_jtag == 1, "R11 jtag granted", 64'(gnt_jtag), 1);
    req_ext = 1;
    #100;
    check(gnt_ext == 0, "R10 ext denied under jtag", 64'(gnt_ext), 0);

    // R5: release; jtag ends, ext wins over int
    load_ir(REL, cap);
    check(init_conf_n == 1, "R5 release drives high", 64'(init_conf_n), 1);
    #100;
    check(gnt_ext == 1, "R8 ext after jtag", 64'(gnt_ext), 1);

    // R9 / R11: programming without hold waits for ext to drop
    load_ir(PROG, cap);
    #100;
    check(gnt_ext && !gnt_jtag, "R9 ext not preempted",
          64'({gnt_jtag, gnt_ext}), 1);
    req_ext = 0;
    #60;
    check(gnt_jtag == 1, "R11 jtag without hold", 64'(gnt_jtag), 1);

    // R6: TLR clears hold and programming
    load_ir(HOLD, cap);
    tap_reset();
    check(init_conf_n == 1, "R6 tlr releases", 64'(init_conf_n), 1);
    #100;
    check(gnt_int && !gnt_jtag, "R6 jtag ended, int back",
          64'({gnt_jtag, gnt_int}), 1);

    // same-edge collision: hold strips int while ext rises
    load_ir(HOLD, cap);
    #40; req_ext = 1;
    #100;
    check(gnt_ext && !gnt_int, "R7 ext wins as int is stripped",
          64'({gnt_ext, gnt_int}), 2);
    req_ext = 0;
    load_ir(REL, cap);
    #100;
    check(gnt_int == 1, "R9 int returns after release", 64'(gnt_int), 1);
    req_int = 0;
    #100;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule